// File: doc/BRIEF.md
# Multiplexed Open-Drain Address Port

This block is one byte-wide I/O port. It either serves as a general-purpose port or carries the low byte of an external-memory address. Each bit has a storage latch that software writes through a strobe. Each bit also has drive-control logic that turns the latch, or the address, into three per-pin controls: pull low, drive high, or release. The pin levels are resolved outside the block, by a board model in the bench. That model supplies a pull-up or an external source wherever a pin is released. The block samples those levels for the pin read.

In port mode the outputs are open-drain. A stored 0 pulls the pin low. A stored 1 releases it, so an external pull-up or an external driver sets the level. A bit is used as an input by first writing 1 to its latch. In external-access mode both drivers are active and follow the address bits. The latches keep their contents while that mode is active and take over again as soon as it ends. The write strobe and the mode select are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `mux_od_port`

## Requirements
- R1: After reset every latch bit is 1. With port mode selected, every release output is 1 and every pull-low and drive-high output is 0. The pin read resets to all ones.
- R2: In port mode, a latch bit of 0 asserts that bit's pull-low output and deasserts its drive-high and release outputs.
- R3: In port mode, a latch bit of 1 asserts only that bit's release output. Both drivers are off.
- R4: With port mode selected, a write strobe stores the write data. The latch read shows the new value after the next rising clock edge.
- R5: In external-access mode, each address bit of 1 asserts drive-high only, and each address bit of 0 asserts pull-low only. Release is 0 for every bit.
- R6: A write strobe made while external-access mode is selected is ignored, and the latch contents stay unchanged.
- R7: When external-access mode is deasserted, the drive outputs follow the stored latch again in the same cycle.
- R8: The pin read returns the resolved pin levels sampled at the previous rising clock edge.
- R9: For every bit, exactly one of pull-low, drive-high and release is asserted. Pull-low and drive-high are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Data to store in the latches |
| ext_mode | input | 1 | 1 selects external-access (address) mode |
| ext_addr | input | 8 | Low address byte driven in external-access mode |
| pin_lvl | input | 8 | Resolved pin levels from outside |
| latch_q | output | 8 | Latch read, for read-modify-write |
| pin_rd | output | 8 | Sampled pin levels |
| drv_low | output | 8 | Per-pin pull-low enable |
| drv_high | output | 8 | Per-pin drive-high enable |
| drv_rel | output | 8 | Per-pin release (both drivers off) |

## Verification
Port mode is tried with latch values of all zeros, all ones and mixed patterns. The released bits are placed against external levels that differ from the latch, which separates a floating pin from a driven one in the pin read. Address mode is tried with alternating, all-one and all-zero bytes, together with write strobes. This shows that the drivers follow the address rather than the latch, and that the latch ignores those writes. Stepping back to port mode, and a reset applied in the middle of the run, confirm that the latch value survives address mode and that the reset state returns.

// File: rtl/mux_od_port_pkg.sv
package mux_od_port_pkg;
  localparam int unsigned PORT_W = 8;
  typedef enum logic {MODE_PORT = 1'b0, MODE_ADDR = 1'b1} port_mode_e;
  typedef struct packed {
    logic low;
    logic high;
    logic rel;
  } pin_drv_t;
endpackage

// File: rtl/mux_od_latch_bank.sv
module mux_od_latch_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         hold,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic take;
  assign take = wr_en && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '1;
    else if (take) q <= wr_data;
  end
endmodule

// File: rtl/mux_od_drive_ctl.sv
module mux_od_drive_ctl
  import mux_od_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  port_mode_e   mode,
  input  logic [W-1:0] latch_v,
  input  logic [W-1:0] addr,
  output logic [W-1:0] low,
  output logic [W-1:0] high,
  output logic [W-1:0] rel
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    pin_drv_t d;
    always_comb begin
      d = '{low: 1'b0, high: 1'b0, rel: 1'b1};
      if (mode == MODE_ADDR) begin
        d.low  = !addr[b];
        d.high = addr[b];
        d.rel  = 1'b0;
      end else if (!latch_v[b]) begin
        d.low = 1'b1;
        d.rel = 1'b0;
      end
    end
    assign low[b]  = d.low;
    assign high[b] = d.high;
    assign rel[b]  = d.rel;
  end
endmodule

// File: rtl/mux_od_pin_sampler.sv
module mux_od_pin_sampler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= lvl;
  end
endmodule

// File: rtl/mux_od_port.sv
module mux_od_port
  import mux_od_port_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         ext_mode,
  input  logic [W-1:0] ext_addr,
  input  logic [W-1:0] pin_lvl,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] pin_rd,
  output logic [W-1:0] drv_low,
  output logic [W-1:0] drv_high,
  output logic [W-1:0] drv_rel
);
  port_mode_e mode;
  assign mode = ext_mode ? MODE_ADDR : MODE_PORT;

  mux_od_latch_bank #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hold(ext_mode),
    .wr_data(wr_data), .q(latch_q)
  );

  mux_od_drive_ctl #(.W(W)) u_drive (
    .mode(mode), .latch_v(latch_q), .addr(ext_addr),
    .low(drv_low), .high(drv_high), .rel(drv_rel)
  );

  mux_od_pin_sampler #(.W(W)) u_sample (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .q(pin_rd)
  );
endmodule

// File: rtl/mux_od_port_chk.sv
module mux_od_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         ext_mode,
  input logic [W-1:0] ext_addr,
  input logic [W-1:0] pin_lvl,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] pin_rd,
  input logic [W-1:0] drv_low,
  input logic [W-1:0] drv_high,
  input logic [W-1:0] drv_rel
);
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_low & drv_high) == '0);
  a_r9_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_low | drv_high | drv_rel) == '1) && ((drv_rel & (drv_low | drv_high)) == '0));
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ext_mode) |=> latch_q == $past(wr_data));
  a_r6_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |=> $stable(latch_q));
  a_r5_addr_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (drv_high == ext_addr) && (drv_low == ~ext_addr));
  a_r2_low_from_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> drv_low == ~latch_q);
  a_r3_float_from_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> (drv_rel == latch_q) && (drv_high == '0));
  a_r8_pin_sample: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pin_rd == $past(pin_lvl));
endmodule

bind mux_od_port mux_od_port_chk #(.W(W)) u_chk (.*);

// File: tb/test_mux_od_port.sv
module test_mux_od_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ext_mode = 1'b0;
  logic [7:0] ext_addr = '0;
  logic [7:0] ext_lvl = 8'hFF;
  logic [7:0] pin_lvl;
  logic [7:0] latch_q, pin_rd, drv_low, drv_high, drv_rel;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  // board model: driven high, pulled low, or external level when released
  assign pin_lvl = drv_high | (~drv_low & ext_lvl);

  mux_od_port i_mux_od_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ext_mode(ext_mode), .ext_addr(ext_addr), .pin_lvl(pin_lvl),
    .latch_q(latch_q), .pin_rd(pin_rd), .drv_low(drv_low),
    .drv_high(drv_high), .drv_rel(drv_rel)
  );

  // {mode, wen, wdata, addr, ext level}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h00, 8'h00, 8'hFF},
    {1'b0, 1'b1, 8'hA5, 8'h00, 8'h0F},
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h3C},
    {1'b1, 1'b1, 8'h00, 8'h5A, 8'h00},
    {1'b1, 1'b0, 8'h00, 8'hC3, 8'hFF},
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h55},
    {1'b0, 1'b1, 8'hFF, 8'h00, 8'h96},
    {1'b1, 1'b0, 8'h00, 8'hFF, 8'h00},
    {1'b1, 1'b1, 8'h12, 8'h00, 8'hFF},
    {1'b0, 1'b1, 8'h81, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] m_latch;
    logic [7:0] e_low, e_high, e_rel, e_pin;
    logic prev_mode;
    m_latch = 8'hFF;
    prev_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 latch", latch_q, 8'hFF);
    chk("R1 rel", drv_rel, 8'hFF);
    chk("R1 low", drv_low, 8'h00);
    chk("R1 high", drv_high, 8'h00);
    chk("R1 pin_rd", pin_rd, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {ext_mode, wr_en, wr_data, ext_addr, ext_lvl} = VEC[i];
      // drive before edge uses old latch and new mode
      e_low  = ext_mode ? ~ext_addr : ~m_latch;
      e_high = ext_mode ? ext_addr : 8'h00;
      e_pin  = e_high | (~e_low & ext_lvl);
      @(posedge clk);
      if (wr_en && !ext_mode) m_latch = wr_data;
      #1;
      e_low  = ext_mode ? ~ext_addr : ~m_latch;
      e_high = ext_mode ? ext_addr : 8'h00;
      e_rel  = ext_mode ? 8'h00 : m_latch;
      if (ext_mode) begin
        chk("R6 latch held", latch_q, m_latch);
        chk("R5 low", drv_low, e_low);
        chk("R5 high", drv_high, e_high);
        chk("R5 rel", drv_rel, e_rel);
      end else begin
        chk("R4 latch", latch_q, m_latch);
        chk(prev_mode ? "R7 low" : "R2 low", drv_low, e_low);
        chk(prev_mode ? "R7 high" : "R3 high", drv_high, e_high);
        chk(prev_mode ? "R7 rel" : "R3 rel", drv_rel, e_rel);
      end
      chk("R9 overlap", drv_low & drv_high, 8'h00);
      chk("R8 pin_rd", pin_rd, e_pin);
      prev_mode = ext_mode;
      @(negedge clk);
    end

    // directed: R6 ignored write seen after leaving address mode
    wr_en = 1'b1; wr_data = 8'h3C; ext_mode = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hC0; ext_mode = 1'b1; ext_addr = 8'hAA;
    @(negedge clk);
    wr_en = 1'b0; ext_mode = 1'b0;
    #1;
    chk("R6 write ignored", latch_q, 8'h3C);
    chk("R7 low after exit", drv_low, 8'hC3);

    // directed: R8 input use on released bits
    wr_en = 1'b1; wr_data = 8'hFF; ext_lvl = 8'h69;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R8 input read", pin_rd, 8'h69);

    // directed: reset mid-run returns R1 state
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 latch after reset", latch_q, 8'hFF);
    chk("R1 rel after reset", drv_rel, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule